// File: doc/BRIEF.md
# Dual-Direction Latching Bus Transceiver

This block couples two 18-bit buses, called A and B, through two channels that mirror each other and never share state: one carries A toward B, the other carries B toward A. Every channel has four controls of its own: a drive enable that is active low, a pass-through select, a capture strobe, and a strobe gate that is active low. With pass-through asserted, the channel output tracks its input in the same cycle. With pass-through deasserted, the output shows a stored word. That word is replaced only when the capture strobe rises while the gate is open.

The block runs on a single system clock. Each capture strobe is handled as a slow control level, sampled every system cycle, and a rise is found by comparing the current sample with the previous one. There is no three-state logic inside the block. Each channel instead presents a data vector and a per-bit drive vector, and a pad wrapper combines the two into a tri-state driver. The data vector stays valid while driving is off. Only the drive vector follows the drive enable.

The data paths carry plain control and data levels, with no handshake. They pass a word in every cycle and never apply back-pressure.

Top module: `bus_xcvr`

## Requirements
- R1: A channel's drive vector is all zeros in any cycle where its drive enable input is 1, and all ones where it is 0. The drive enable has no effect on the data vector.
- R2: With pass-through at 1, a channel's data output equals its data input in the same cycle.
- R3: With pass-through at 0 and the gate at 0, a strobe sampled 0 in one system cycle and 1 in the next stores the input word present in that second cycle. The stored word appears on the output one system clock edge later.
- R4: With pass-through at 0, a strobe that stays at 0, stays at 1, or falls leaves the stored word and the output unchanged.
- R5: With pass-through at 0 and the gate at 1, a rising strobe is ignored and the stored word is held.
- R6: When pass-through falls from 1 to 0, the output holds the input word from the last cycle in which pass-through was 1.
- R7: The stored word keeps updating by pass-through and by capture while the drive enable is 1 (driving off).
- R8: The A-to-B and B-to-A channels are independent: stimulus on one never changes the other's outputs.
- R9: Reset (rst_n low) clears both stored words to zero. A strobe that is already at 1 when reset is released is not counted as a rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears stored words |
| a_in | input | 18 | Word sampled from the A bus |
| b_in | input | 18 | Word sampled from the B bus |
| ab_drv_n | input | 1 | A-to-B drive enable, active low |
| ab_pass | input | 1 | A-to-B pass-through select |
| ab_stb | input | 1 | A-to-B capture strobe |
| ab_gate_n | input | 1 | A-to-B strobe gate, active low |
| ba_drv_n | input | 1 | B-to-A drive enable, active low |
| ba_pass | input | 1 | B-to-A pass-through select |
| ba_stb | input | 1 | B-to-A capture strobe |
| ba_gate_n | input | 1 | B-to-A strobe gate, active low |
| b_out | output | 18 | Data toward the B bus |
| b_oe | output | 18 | Per-bit drive enable for the B bus |
| a_out | output | 18 | Data toward the A bus |
| a_oe | output | 18 | Per-bit drive enable for the A bus |

## Verification
The assertions assume that every strobe, gate, pass-through and data input is a level that settles within one system cycle. They also assume a strobe stays at each level for at least one full cycle, so that a rise appears as a 0 sample followed by a 1 sample. The bench respects this by changing all inputs once per cycle, one nanosecond after the rising clock edge. It never pulses a strobe within a cycle. The sweep walks every combination of pass-through, gate, strobe start level and strobe end level on both channels at once, and runs the two channels in opposite order so that their settings differ.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W = 18;

  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_PASS    = 2'd1,
    MODE_CAPTURE = 2'd2
  } store_mode_e;

  function automatic store_mode_e pick_mode(input logic pass, input logic cap);
    if (pass)     return MODE_PASS;
    else if (cap) return MODE_CAPTURE;
    else          return MODE_HOLD;
  endfunction
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic rise
);
  logic stb_q;

  // Reset to 1 so a strobe already high at release is not a rise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b1;
    else        stb_q <= stb;
  end

  assign rise = stb & ~stb_q;

  AST_RISE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> ($past(stb) == 1'b0)); // R9
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         pass,
  input  logic         cap,
  output logic [W-1:0] q
);
  store_mode_e mode;

  assign mode = pick_mode(pass, cap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      unique case (mode)
        MODE_PASS, MODE_CAPTURE: q <= din;
        default:                 q <= q;
      endcase
    end
  end
endmodule

// File: rtl/xcvr_channel.sv
module xcvr_channel
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         drv_n,
  input  logic         pass,
  input  logic         stb,
  input  logic         gate_n,
  output logic [W-1:0] dout,
  output logic [W-1:0] oe
);
  logic         rise;
  logic         cap;
  logic [W-1:0] q;

  xcvr_edge_det u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .stb  (stb),
    .rise (rise)
  );

  assign cap = rise & ~gate_n;

  xcvr_store #(.W(W)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (din),
    .pass (pass),
    .cap  (cap),
    .q    (q)
  );

  assign dout = pass ? din : q;

  // Per-bit drive vector; the wrapper builds the tri-state from it
  generate
    for (genvar i = 0; i < int'(W); i++) begin : g_oe
      assign oe[i] = ~drv_n;
    end
  endgenerate

  AST_PASS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    pass |=> (q == $past(din))); // R6
  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && rise && !gate_n) |=> (q == $past(din))); // R3
  AST_GATED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && rise && gate_n) |=> $stable(q)); // R5
  AST_NO_RISE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && !rise) |=> $stable(q)); // R4
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_drv_n,
  input  logic         ab_pass,
  input  logic         ab_stb,
  input  logic         ab_gate_n,
  input  logic         ba_drv_n,
  input  logic         ba_pass,
  input  logic         ba_stb,
  input  logic         ba_gate_n,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe
);
  xcvr_channel #(.W(W)) u_ab (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (a_in),
    .drv_n (ab_drv_n),
    .pass  (ab_pass),
    .stb   (ab_stb),
    .gate_n(ab_gate_n),
    .dout  (b_out),
    .oe    (b_oe)
  );

  xcvr_channel #(.W(W)) u_ba (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (b_in),
    .drv_n (ba_drv_n),
    .pass  (ba_pass),
    .stb   (ba_stb),
    .gate_n(ba_gate_n),
    .dout  (a_out),
    .oe    (a_oe)
  );

  AST_DRIVE_FOLLOWS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ab_drv_n) |-> (b_oe == '0)); // R1
  AST_DRIVE_ON_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ba_drv_n) |-> (&a_oe)); // R1
endmodule

// File: tb/bus_xcvr_bench.sv
`timescale 1ns/1ps
module bus_xcvr_bench;
  localparam int W = 18;
  localparam logic [W-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_drv_n = 1'b1, ab_pass = 1'b0, ab_stb = 1'b1, ab_gate_n = 1'b1;
  logic ba_drv_n = 1'b1, ba_pass = 1'b0, ba_stb = 1'b1, ba_gate_n = 1'b1;
  logic [W-1:0] b_out, b_oe, a_out, a_oe;

  int checks = 0;
  int fails = 0;

  // reference state
  logic [W-1:0] m_ab_q = '0, m_ba_q = '0;
  logic m_ab_prev = 1'b1, m_ba_prev = 1'b1;
  logic m_ab_lastpass = 1'b0, m_ba_lastpass = 1'b0;

  always #2 clk = ~clk;

  bus_xcvr u_bus_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_drv_n(ab_drv_n), .ab_pass(ab_pass), .ab_stb(ab_stb), .ab_gate_n(ab_gate_n),
    .ba_drv_n(ba_drv_n), .ba_pass(ba_pass), .ba_stb(ba_stb), .ba_gate_n(ba_gate_n),
    .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_for(input logic pass, input logic lastpass,
                                    input logic prev, input logic stb,
                                    input logic gate_n, input logic drv_n);
    if (pass) return "R2";
    if (lastpass) return "R6";
    if (stb && !prev) return gate_n ? "R5" : (drv_n ? "R7" : "R3");
    return "R4";
  endfunction

  // check outputs against model, then advance model across one edge
  task automatic step();
    logic [W-1:0] exp_b, exp_a;
    #1;
    exp_b = ab_pass ? a_in : m_ab_q;
    exp_a = ba_pass ? b_in : m_ba_q;
    chk(tag_for(ab_pass, m_ab_lastpass, m_ab_prev, ab_stb, ab_gate_n, ab_drv_n), b_out, exp_b);
    chk(tag_for(ba_pass, m_ba_lastpass, m_ba_prev, ba_stb, ba_gate_n, ba_drv_n), a_out, exp_a);
    chk("R1", b_oe, ab_drv_n ? '0 : MASK);
    chk("R1", a_oe, ba_drv_n ? '0 : MASK);
    if (ab_pass || (ab_stb && !m_ab_prev && !ab_gate_n)) m_ab_q = a_in;
    if (ba_pass || (ba_stb && !m_ba_prev && !ba_gate_n)) m_ba_q = b_in;
    m_ab_prev = ab_stb; m_ba_prev = ba_stb;
    m_ab_lastpass = ab_pass; m_ba_lastpass = ba_pass;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R9: outputs cleared, strobe high across release is no rise
    ab_gate_n = 1'b0; ba_gate_n = 1'b0;
    a_in = 18'h2AAAA; b_in = 18'h15555;
    step();
    chk("R9", b_out, '0);
    chk("R9", a_out, '0);

    // sweep all control combinations on both channels, mirrored order
    for (int rep = 0; rep < 4; rep++) begin
      for (int i = 0; i < 16; i++) begin
        int j;
        j = 15 - i;
        ab_pass = i[0]; ab_gate_n = i[1]; ab_drv_n = rep[0] ^ i[2];
        ba_pass = j[0]; ba_gate_n = j[1]; ba_drv_n = rep[1] ^ j[3];
        ab_stb = i[2]; ba_stb = j[2];
        a_in = W'((i * 9731 + rep * 40503 + 7) & 32'h3FFFF);
        b_in = W'((j * 5179 + rep * 22229 + 3) & 32'h3FFFF);
        step();
        ab_stb = i[3]; ba_stb = j[3];
        a_in = W'((i * 20011 + rep * 1013 + 91) & 32'h3FFFF);
        b_in = W'((j * 30137 + rep * 7919 + 45) & 32'h3FFFF);
        step();
        ab_pass = 1'b0; ba_pass = 1'b0;
        a_in = ~a_in; b_in = ~b_in;
        step();
      end
    end

    // R8: churn A-to-B only, B-to-A output must not move
    ba_pass = 1'b0; ba_stb = 1'b0; ba_gate_n = 1'b1;
    step();
    begin
      logic [W-1:0] held;
      held = a_out;
      ab_gate_n = 1'b0; ab_pass = 1'b0;
      for (int k = 0; k < 6; k++) begin
        ab_stb = k[0];
        a_in = W'((k * 12345 + 17) & 32'h3FFFF);
        b_in = W'((k * 777 + 5) & 32'h3FFFF);
        step();
        chk("R8", a_out, held);
      end
    end

    // R7: capture while drive is off, then enable and observe
    ab_drv_n = 1'b1; ab_pass = 1'b0; ab_gate_n = 1'b0; ab_stb = 1'b0;
    a_in = 18'h0F0F0;
    step();
    ab_stb = 1'b1;
    step();
    ab_drv_n = 1'b0; a_in = 18'h00001;
    step();
    chk("R7", b_out, 18'h0F0F0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule